// File: doc/BRIEF.md
# Dual-Thread Partitioned Queue with Mode Recombination

This block is a decoupling queue placed between two pipeline stages that carry work for two hardware threads. Each thread has its own push port, pop port and show-ahead read port, and its entries come back in its own arrival order. All entries are drawn from one pool of `DEPTH` slots. When both threads run, each is held to half the pool, so a thread whose consumer stalls cannot starve the other of slots.

A small mode controller keeps a two-bit active-thread vector. Per-thread halt pulses clear the thread's bit and per-thread interrupt pulses set it. When only one thread is active, its cap rises to the whole pool, minus whatever the halted thread still holds. When no thread is active, the block raises a low-power flag. A change of mode never discards entries. A thread whose occupancy is above its new cap stays full until pops bring it back under the cap.

Top module: `dual_thread_queue`

## Requirements
- R1: After reset, `mode` is 2'b11 (both threads active), `lowPower` is 0, both `valid` bits are 0 and both `full` bits are 0.
- R2: Each thread is a show-ahead FIFO. `rdDataN` shows that thread's oldest entry while `valid[N]` is 1, and a pop removes it. Pops on one thread never return the other thread's data, and a pop on an empty thread has no effect.
- R3: In mode 2'b11, a thread accepts at most `DEPTH/2` entries. Its `full` bit is 1 at that occupancy and further pushes are ignored, while the other thread's `full` bit stays unaffected.
- R4: In a single-thread mode, the active thread may hold up to `DEPTH` minus the halted thread's occupancy. With the halted thread empty, it fills all `DEPTH` entries.
- R5: A thread whose mode bit is 0 reports `full` = 1 and its pushes are ignored. Its existing entries can still be popped in order.
- R6: A halt on thread 0 alone in mode 2'b11 gives mode 2'b10 (only thread 1 active) on the next cycle. A halt on thread 1 alone gives 2'b01 (only thread 0 active). Halts on both in the same cycle give 2'b00.
- R7: The next active vector is (active AND NOT halt) OR interrupt. An interrupt to the halted thread in a single-thread mode returns the block to 2'b11. An interrupt to an already active thread changes nothing. An interrupt beats a halt to the same thread in the same cycle.
- R8: A halt on the remaining active thread gives mode 2'b00 with `lowPower` = 1. From there, an interrupt to one thread gives that thread's single-thread mode and clears `lowPower`. Interrupts to both threads give 2'b11.
- R9: A mode change never drops entries. A thread whose occupancy is at or above its new cap keeps `full` = 1 and has its pushes ignored until pops bring its occupancy below the cap.
- R10: The two threads together never hold more than `DEPTH` entries. A thread's cap is the smaller of its mode share and `DEPTH` minus the other thread's occupancy.
- R11: A push and a pop on the same non-full, non-empty thread in one cycle both take effect, and the occupancy stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| push | input | 2 | Push request, bit N for thread N |
| wrData0 | input | DATA_W | Data pushed by thread 0 |
| wrData1 | input | DATA_W | Data pushed by thread 1 |
| pop | input | 2 | Pop request, bit N for thread N |
| halt | input | 2 | Halt pulse, bit N for thread N |
| intr | input | 2 | Interrupt pulse, bit N for thread N |
| rdData0 | output | DATA_W | Oldest entry of thread 0 |
| rdData1 | output | DATA_W | Oldest entry of thread 1 |
| valid | output | 2 | Thread N holds at least one entry |
| full | output | 2 | Thread N is at or above its current cap |
| mode | output | 2 | Active-thread vector: 11 both, 01 thread 0 only, 10 thread 1 only, 00 none |
| lowPower | output | 1 | No thread is active |

## Verification
The assertions take as given that the inputs are known, two-valued values on every clock edge after reset. Halt and interrupt are treated as single-cycle pulses. A push while `full` is 1 or a pop while `valid` is 0 is treated as a legal request that the block must ignore. The directed stimulus changes inputs only on the falling edge and holds every pulse for exactly one rising edge. It deliberately sends pushes into full or halted threads and pops into empty ones, so that the ignore paths are exercised inside these assumptions.

// File: rtl/dtq_pkg.sv
package dtq_pkg;

  typedef enum logic [1:0] {
    MODE_NONE  = 2'b00,
    MODE_ONLY0 = 2'b01,
    MODE_ONLY1 = 2'b10,
    MODE_BOTH  = 2'b11
  } mode_e;

  // strobes from control to datapath, bit N belongs to thread N
  typedef struct packed {
    logic [1:0] pushEn;
    logic [1:0] popEn;
  } dtq_strobe_t;

endpackage

// File: rtl/dtq_ctrl.sv
module dtq_ctrl
  import dtq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       push,
  input  logic [1:0]       pop,
  input  logic [1:0]       halt,
  input  logic [1:0]       intr,
  input  logic [CNT_W-1:0] occ [2],
  output dtq_strobe_t      strobe,
  output logic [1:0]       full,
  output mode_e            mode,
  output logic             lowPower
);

  localparam logic [CNT_W-1:0] POOL_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(DEPTH / 2);

  logic [1:0] activeQ;

  // active vector: halts clear bits, interrupts set them and win ties
  always_ff @(posedge clk) begin
    if (!rstN) activeQ <= 2'b11;
    else       activeQ <= (activeQ & ~halt) | intr;
  end

  assign mode     = mode_e'(activeQ);
  assign lowPower = (activeQ == 2'b00);

  for (genvar t = 0; t < 2; t++) begin : g_thread
    localparam int OTHER = 1 - t;
    logic [CNT_W-1:0] share;
    logic [CNT_W-1:0] room;
    logic [CNT_W-1:0] limit;

    always_comb begin
      if (activeQ == 2'b11)  share = HALF_C;
      else if (activeQ[t])   share = POOL_C;
      else                   share = '0;
      room  = POOL_C - occ[OTHER];
      limit = (share < room) ? share : room;
    end

    assign full[t]          = (occ[t] >= limit);
    assign strobe.pushEn[t] = push[t] & ~full[t];
    assign strobe.popEn[t]  = pop[t] & (occ[t] != '0);
  end

endmodule

// File: rtl/dtq_datapath.sv
module dtq_datapath
  import dtq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dtq_strobe_t       strobe,
  input  logic [DATA_W-1:0] wrData [2],
  output logic [DATA_W-1:0] rdData [2],
  output logic [CNT_W-1:0]  occ [2],
  output logic [1:0]        valid
);

  localparam logic [PTR_W-1:0] LAST_C = PTR_W'(DEPTH - 1);

  // every thread owns a ring large enough for the whole pool;
  // the control caps keep the sum within DEPTH
  for (genvar t = 0; t < 2; t++) begin : g_ring
    logic [DATA_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wrPtr;
    logic [PTR_W-1:0]  rdPtr;
    logic [CNT_W-1:0]  count;

    always_ff @(posedge clk) begin
      if (strobe.pushEn[t]) slots[wrPtr] <= wrData[t];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else begin
        if (strobe.pushEn[t]) wrPtr <= (wrPtr == LAST_C) ? '0 : wrPtr + 1'b1;
        if (strobe.popEn[t])  rdPtr <= (rdPtr == LAST_C) ? '0 : rdPtr + 1'b1;
        count <= count + CNT_W'(strobe.pushEn[t]) - CNT_W'(strobe.popEn[t]);
      end
    end

    assign rdData[t] = slots[rdPtr];
    assign occ[t]    = count;
    assign valid[t]  = (count != '0);
  end

endmodule

// File: rtl/dual_thread_queue.sv
module dual_thread_queue
  import dtq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        push,
  input  logic [DATA_W-1:0] wrData0,
  input  logic [DATA_W-1:0] wrData1,
  input  logic [1:0]        pop,
  input  logic [1:0]        halt,
  input  logic [1:0]        intr,
  output logic [DATA_W-1:0] rdData0,
  output logic [DATA_W-1:0] rdData1,
  output logic [1:0]        valid,
  output logic [1:0]        full,
  output logic [1:0]        mode,
  output logic              lowPower
);

  dtq_strobe_t       strobe;
  mode_e             modeInt;
  logic [CNT_W-1:0]  occ [2];
  logic [DATA_W-1:0] wrVec [2];
  logic [DATA_W-1:0] rdVec [2];

  assign wrVec[0] = wrData0;
  assign wrVec[1] = wrData1;
  assign rdData0  = rdVec[0];
  assign rdData1  = rdVec[1];
  assign mode     = modeInt;

  dtq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .push     (push),
    .pop      (pop),
    .halt     (halt),
    .intr     (intr),
    .occ      (occ),
    .strobe   (strobe),
    .full     (full),
    .mode     (modeInt),
    .lowPower (lowPower)
  );

  dtq_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrVec),
    .rdData (rdVec),
    .occ    (occ),
    .valid  (valid)
  );

endmodule

// File: rtl/dtq_checker.sv
module dtq_checker #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       push,
  input logic [1:0]       pop,
  input logic [1:0]       halt,
  input logic [1:0]       intr,
  input logic [1:0]       full,
  input logic [1:0]       valid,
  input logic [1:0]       mode,
  input logic             lowPower,
  input logic [CNT_W-1:0] occ [2]
);

  localparam int HALF = DEPTH / 2;

  p_pool_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    (int'(occ[0]) + int'(occ[1])) <= DEPTH);

  p_share_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b11 && push[0] && !full[0]) |-> (int'(occ[0]) < HALF));

  p_halted_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!mode[0] || !mode[1]) |-> ((mode[0] || full[0]) && (mode[1] || full[1])));

  p_halt_one_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b11 && halt == 2'b01 && intr == 2'b00) |=> (mode == 2'b10));

  p_wake_both_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01 && intr[1] && !halt[0]) |=> (mode == 2'b11));

  p_last_halt_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01 && halt[0] && intr == 2'b00) |=> lowPower);

  p_no_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!pop[0]) |=> (occ[0] >= $past(occ[0])));

  p_same_cycle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (push[1] && pop[1] && valid[1] && !full[1]) |=> $stable(occ[1]));

endmodule

bind dual_thread_queue dtq_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/dual_thread_queue_bench.sv
module dual_thread_queue_bench;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        push = '0;
  logic [1:0]        pop = '0;
  logic [1:0]        halt = '0;
  logic [1:0]        intr = '0;
  logic [DATA_W-1:0] wrData0 = '0;
  logic [DATA_W-1:0] wrData1 = '0;
  logic [DATA_W-1:0] rdData0;
  logic [DATA_W-1:0] rdData1;
  logic [1:0]        valid;
  logic [1:0]        full;
  logic [1:0]        mode;
  logic              lowPower;

  int nChecks = 0;
  int nFails  = 0;

  dual_thread_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dual_thread_queue (
    .clk(clk), .rstN(rstN), .push(push), .wrData0(wrData0), .wrData1(wrData1),
    .pop(pop), .halt(halt), .intr(intr), .rdData0(rdData0), .rdData1(rdData1),
    .valid(valid), .full(full), .mode(mode), .lowPower(lowPower)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    push = '0; pop = '0; halt = '0; intr = '0;
  endtask

  task automatic pushOne(input int t, input logic [7:0] d);
    if (t == 0) wrData0 = d; else wrData1 = d;
    push[t] = 1'b1;
    tick();
  endtask

  task automatic popHead(input int t, input int exp, input string req);
    check(req, int'(valid[t]), 1);
    check(req, (t == 0) ? int'(rdData0) : int'(rdData1), exp);
    pop[t] = 1'b1;
    tick();
  endtask

  task automatic pulse(input logic [1:0] h, input logic [1:0] i);
    halt = h; intr = i;
    tick();
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 mode", int'(mode), 3);
    check("R1 lowPower", int'(lowPower), 0);
    check("R1 valid", int'(valid), 0);
    check("R1 full", int'(full), 0);
  endtask

  task automatic t_order();
    wrData0 = 8'h10; wrData1 = 8'h20; push = 2'b11; tick();
    wrData0 = 8'h11; wrData1 = 8'h21; push = 2'b11; tick();
    pushOne(0, 8'h12);
    check("R2 head1", int'(rdData1), 'h20);
    popHead(1, 'h20, "R2 t1 first");
    popHead(0, 'h10, "R2 t0 first");
    popHead(0, 'h11, "R2 t0 second");
    popHead(1, 'h21, "R2 t1 second");
    popHead(0, 'h12, "R2 t0 third");
    pop = 2'b11; tick();
    check("R2 empty pop ignored", int'(valid), 0);
    check("R2 empty pop no full", int'(full), 0);
  endtask

  task automatic t_share();
    for (int i = 0; i < 3; i++) pushOne(0, 8'(8'h30 + i));
    check("R3 below half", int'(full[0]), 0);
    pushOne(0, 8'h33);
    check("R3 at half full", int'(full[0]), 1);
    check("R3 other not full", int'(full[1]), 0);
    pushOne(0, 8'h34);
    pushOne(0, 8'h35);
    for (int i = 0; i < 4; i++) popHead(0, 'h30 + i, "R3 drain");
    check("R3 extra pushes ignored", int'(valid[0]), 0);
  endtask

  task automatic t_sameCycle();
    pushOne(1, 8'h40);
    pushOne(1, 8'h41);
    wrData1 = 8'h42; push[1] = 1'b1; pop[1] = 1'b1; tick();
    popHead(1, 'h41, "R11 after push+pop");
    popHead(1, 'h42, "R11 new entry");
    check("R11 count kept", int'(valid[1]), 0);
  endtask

  task automatic t_recombine();
    pushOne(1, 8'h50);
    pushOne(1, 8'h51);
    pulse(2'b10, 2'b00);
    check("R6 halt1 -> only0", int'(mode), 1);
    check("R5 halted full", int'(full[1]), 1);
    pushOne(1, 8'h5F);
    for (int i = 0; i < 8; i++) pushOne(0, 8'(8'h60 + i));
    check("R4 limited by halted occupancy", int'(full[0]), 1);
    popHead(1, 'h50, "R5 halted drain");
    popHead(1, 'h51, "R5 halted drain");
    check("R5 halted push ignored", int'(valid[1]), 0);
    check("R4 room regained", int'(full[0]), 0);
    pushOne(0, 8'h66);
    pushOne(0, 8'h67);
    check("R4 whole pool full", int'(full[0]), 1);
    pulse(2'b00, 2'b10);
    check("R7 intr1 -> both", int'(mode), 3);
    check("R9 over cap full", int'(full[0]), 1);
    check("R10 no room for t1", int'(full[1]), 1);
    pushOne(0, 8'h6F);
    pushOne(1, 8'h5E);
    check("R10 t1 push ignored", int'(valid[1]), 0);
    for (int i = 0; i < 4; i++) popHead(0, 'h60 + i, "R9 kept order");
    check("R9 still full at half", int'(full[0]), 1);
    check("R10 t1 share back", int'(full[1]), 0);
    popHead(0, 'h64, "R9 kept order");
    check("R9 below cap", int'(full[0]), 0);
    pushOne(0, 8'h68);
    popHead(0, 'h65, "R9 no drop");
    popHead(0, 'h66, "R9 no drop");
    popHead(0, 'h67, "R9 no drop");
    popHead(0, 'h68, "R9 blocked push absent");
    check("R9 drained", int'(valid[0]), 0);
  endtask

  task automatic t_modes();
    pulse(2'b00, 2'b01);
    check("R7 intr to active", int'(mode), 3);
    pulse(2'b01, 2'b00);
    check("R6 halt0 -> only1", int'(mode), 2);
    pulse(2'b10, 2'b00);
    check("R8 sleep mode", int'(mode), 0);
    check("R8 lowPower", int'(lowPower), 1);
    check("R5 sleep full", int'(full), 3);
    pushOne(0, 8'h77);
    pulse(2'b00, 2'b01);
    check("R8 wake t0", int'(mode), 1);
    check("R8 lowPower clear", int'(lowPower), 0);
    check("R5 sleep push ignored", int'(valid[0]), 0);
    pulse(2'b01, 2'b01);
    check("R7 intr beats halt", int'(mode), 1);
    pulse(2'b10, 2'b00);
    check("R7 halt of halted", int'(mode), 1);
    pulse(2'b00, 2'b10);
    check("R7 back to both", int'(mode), 3);
    pulse(2'b11, 2'b00);
    check("R6 both halt", int'(mode), 0);
    pulse(2'b00, 2'b11);
    check("R8 both wake", int'(mode), 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog R1: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_order();
    t_share();
    t_sameCycle();
    t_recombine();
    t_modes();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule